// File: doc/BRIEF.md
# Write-Protection Unlock Sequencer

This block keeps a group of sensitive control registers (reset-request bits, brown-out detector settings, the power-on-reset disable field and similar) closed to software until a three-byte key has been written, in order, to a single lock-control address. It snoops every bus write. A write to the lock-control address feeds one byte into a key matcher. When the matcher has seen 0x59, then 0x16, then 0x88, the unlock status bit goes to 1. From that point the block lets protected writes through to the rest of the register file.

While the block is locked, a write to any address that the register file decodes as protected is dropped without any error: the block holds its write-permit output low, so the target keeps its old contents. Unprotected addresses are never gated. The lock-control register handles its own writes, and they never reach the register file. Its bit 0 reads back the unlock status. Software cannot set that bit directly.

The sequencer is a six-state machine. Three states are locked: `WS_LOCKED`, `WS_L_KEY1` (first byte seen) and `WS_L_KEY2` (second byte seen). Three mirror them while unlocked: `WS_OPEN`, `WS_O_KEY1` and `WS_O_KEY2`. On a lock-address write carrying byte b, the transitions are:
- b = 0x59 moves any state to the KEY1 state of its own half.
- b = 0x16 moves a KEY1 state to the KEY2 state of the same half.
- b = 0x88 moves a KEY2 state to `WS_OPEN`.
- Any other byte from any state goes to `WS_LOCKED`.

With no lock-address write, the state holds.

Top module: `wp_unlock_guard`

## Requirements
- R1: After reset the block is locked: `unlock_o` is 0, and a read of the lock address returns 0.
- R2: Three successive writes to the lock address whose low byte (`bus_wdata[7:0]`) is 0x59, 0x16 and 0x88 set `unlock_o` from the cycle after the third write. Bits above the low byte are ignored.
- R3: While locked, a write with `prot_hit` = 1 drives `wr_permit` = 0.
- R4: A write with `prot_hit` = 0 to any address other than the lock address gets `wr_permit` = 1 whether locked or not. While unlocked, protected writes also get `wr_permit` = 1. With `bus_we` = 0, `wr_permit` is 0.
- R5: In the cycle of the final key write, the lock register still reads 0 and `unlock_o` is still 0. A protected write in the very next cycle is permitted.
- R6: A wrong byte in the middle of the key restarts matching from the first byte. A 0x59 at any point counts as a fresh first byte.
- R7: While unlocked, a lock-address write that is neither 0x59 nor the next byte of a key already in progress clears `unlock_o` in the next cycle. Writing 0x59 while unlocked keeps the block unlocked.
- R8: Writes to other addresses, and idle cycles, between key bytes leave the match progress and the unlock state unchanged.
- R9: When the lock address is selected, `rd_data` bit 0 equals the unlock state and all other bits are 0. Writing 0x01 to the lock address does not set the bit. For any other address `rd_data` is 0.
- R10: A write to the lock address never asserts `wr_permit`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | AW (12) | Register bus address |
| bus_wdata | input | DW (32) | Register bus write data |
| bus_we | input | 1 | Write enable for the current bus cycle |
| prot_hit | input | 1 | Register-file decode: the current address is protected |
| wr_permit | output | 1 | The register file may commit this write |
| rd_data | output | DW (32) | Read data for the lock-control address, 0 elsewhere |
| unlock_o | output | 1 | Unlock status |

## Verification
The bench targets the following corner cases:
- Keys interrupted by a wrong byte or a repeated 0x59. A matcher that does not restart, or that treats 0x59 as just another wrong byte, would unlock too early or fail to unlock at all.
- The cycle of the final key byte. A design that uses a combinational unlock would show the bit one cycle early.
- Key bytes interleaved with protected and unprotected writes elsewhere. A decoder that matched on the data bus alone would lose its progress, or would let the blocked write through.
- Re-locking by a stray lock write, and a 0x59 written while unlocked. Swapping the two would leave the block open or close it wrongly.
- A write of 0x01, which would set the unlock bit if bit 0 were writable.

// File: rtl/wpu_pkg.sv
package wpu_pkg;

    typedef enum logic [2:0] {
        WS_LOCKED = 3'd0,
        WS_L_KEY1 = 3'd1,
        WS_L_KEY2 = 3'd2,
        WS_OPEN   = 3'd4,
        WS_O_KEY1 = 3'd5,
        WS_O_KEY2 = 3'd6
    } wpu_state_e;

    // Bit 2 of the encoding marks the unlocked half of the state space.
    function automatic logic wpu_is_open(input wpu_state_e s);
        return s[2];
    endfunction

endpackage

// File: rtl/wpu_addr_match.sv
module wpu_addr_match #(
    parameter int          AW        = 12,
    parameter logic [AW-1:0] LOCK_ADDR = 12'h100
) (
    input  logic [AW-1:0] bus_addr,
    input  logic          bus_we,
    output logic          lock_sel,
    output logic          lock_wr
);

    always_comb begin
        lock_sel = (bus_addr == LOCK_ADDR);
        lock_wr  = lock_sel && bus_we;
    end

endmodule

// File: rtl/wpu_seq_fsm.sv
module wpu_seq_fsm
    import wpu_pkg::*;
#(
    parameter int             KEY_W = 8,
    parameter logic [KEY_W-1:0] KEY0  = 8'h59,
    parameter logic [KEY_W-1:0] KEY1  = 8'h16,
    parameter logic [KEY_W-1:0] KEY2  = 8'h88
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lock_wr,
    input  logic [KEY_W-1:0] key_byte,
    output logic             unlocked
);

    wpu_state_e state_q, state_d;
    logic       open_now;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= WS_LOCKED;
        else        state_q <= state_d;
    end

    always_comb begin
        open_now = wpu_is_open(state_q);
        state_d  = state_q;
        if (lock_wr) begin
            if (key_byte == KEY0) begin
                state_d = open_now ? WS_O_KEY1 : WS_L_KEY1;
            end else begin
                unique case (state_q)
                    WS_L_KEY1: state_d = (key_byte == KEY1) ? WS_L_KEY2 : WS_LOCKED;
                    WS_O_KEY1: state_d = (key_byte == KEY1) ? WS_O_KEY2 : WS_LOCKED;
                    WS_L_KEY2,
                    WS_O_KEY2: state_d = (key_byte == KEY2) ? WS_OPEN : WS_LOCKED;
                    WS_LOCKED,
                    WS_OPEN:   state_d = WS_LOCKED;
                    default:   state_d = WS_LOCKED;
                endcase
            end
        end
    end

    always_comb begin
        unlocked = wpu_is_open(state_q);
    end

    // R2: the final key byte opens the block on the next cycle
    a_r2_key2_opens: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_wr && key_byte == KEY2 && (state_q == WS_L_KEY2 || state_q == WS_O_KEY2))
        |=> unlocked);

    // R6: a first key byte always restarts matching
    a_r6_key0_restarts: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_wr && key_byte == KEY0) |=> (state_q == WS_L_KEY1 || state_q == WS_O_KEY1));

    // R7: a stray lock write while open closes the block
    a_r7_relock: assert property (@(posedge clk) disable iff (!rst_n)
        (unlocked && lock_wr && key_byte != KEY0
         && !(state_q == WS_O_KEY1 && key_byte == KEY1)
         && !(state_q == WS_O_KEY2 && key_byte == KEY2))
        |=> !unlocked);

    // R8: without a lock write nothing moves
    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !lock_wr |=> $stable(state_q));

endmodule

// File: rtl/wpu_gate.sv
module wpu_gate #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_we,
    input  logic          prot_hit,
    input  logic          lock_sel,
    input  logic          unlocked,
    output logic          wr_permit,
    output logic [DW-1:0] rd_data
);

    always_comb begin
        wr_permit = bus_we && !lock_sel && (!prot_hit || unlocked);
        rd_data   = '0;
        if (lock_sel) rd_data[0] = unlocked;
    end

    // R3: protected writes are dropped while locked
    a_r3_locked_block: assert property (@(posedge clk) disable iff (!rst_n)
        (prot_hit && !unlocked) |-> !wr_permit);

    // R10: lock-address writes never reach the register file
    a_r10_lock_addr_private: assert property (@(posedge clk) disable iff (!rst_n)
        lock_sel |-> !wr_permit);

    // R9: only bit 0 of the lock register carries information
    a_r9_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        lock_sel |-> (rd_data[DW-1:1] == '0));

endmodule

// File: rtl/wp_unlock_guard.sv
module wp_unlock_guard #(
    parameter int            AW        = 12,
    parameter int            DW        = 32,
    parameter int            KEY_W     = 8,
    parameter logic [AW-1:0] LOCK_ADDR = 12'h100
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    input  logic          bus_we,
    input  logic          prot_hit,
    output logic          wr_permit,
    output logic [DW-1:0] rd_data,
    output logic          unlock_o
);

    logic             lock_sel;
    logic             lock_wr;
    logic             unlocked;
    logic [KEY_W-1:0] key_byte;

    assign key_byte = bus_wdata[KEY_W-1:0];
    assign unlock_o = unlocked;

    wpu_addr_match #(.AW(AW), .LOCK_ADDR(LOCK_ADDR)) u_match (
        .bus_addr (bus_addr),
        .bus_we   (bus_we),
        .lock_sel (lock_sel),
        .lock_wr  (lock_wr)
    );

    wpu_seq_fsm #(.KEY_W(KEY_W)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .lock_wr  (lock_wr),
        .key_byte (key_byte),
        .unlocked (unlocked)
    );

    wpu_gate #(.DW(DW)) u_gate (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_we    (bus_we),
        .prot_hit  (prot_hit),
        .lock_sel  (lock_sel),
        .unlocked  (unlocked),
        .wr_permit (wr_permit),
        .rd_data   (rd_data)
    );

    // R5: opening only ever follows a lock-address write in the prior cycle
    a_r5_open_registered: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(unlock_o) |-> $past(lock_wr));

endmodule

// File: tb/wp_unlock_guard_tb_top.sv
module wp_unlock_guard_tb_top;

    localparam logic [11:0] LOCK = 12'h100;
    localparam logic [11:0] PADR = 12'h018;
    localparam logic [11:0] UADR = 12'h030;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_we = 1'b0;
    logic        prot_hit = 1'b0;
    logic        wr_permit;
    logic [31:0] rd_data;
    logic        unlock_o;

    int compared = 0;
    int mismatched = 0;
    int m_step = 0;
    bit m_unl = 0;

    always #10 clk = ~clk;

    wp_unlock_guard dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .prot_hit(prot_hit), .wr_permit(wr_permit),
        .rd_data(rd_data), .unlock_o(unlock_o)
    );

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic step(input logic [11:0] a, input logic [31:0] d, input logic we,
                        input logic p, input string tag);
        logic [7:0] b;
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = we; prot_hit = p;
        #5;
        chk(tag, "wr_permit", {31'b0, wr_permit},
            {31'b0, we && (a != LOCK) && (!p || m_unl)});
        chk(tag, "rd_data", rd_data, (a == LOCK) ? {31'b0, m_unl} : 32'h0);
        chk(tag, "unlock_o", {31'b0, unlock_o}, {31'b0, m_unl});
        @(posedge clk);
        if (we && a == LOCK) begin
            b = d[7:0];
            if (b == 8'h59)                      m_step = 1;
            else if (m_step == 1 && b == 8'h16)  m_step = 2;
            else if (m_step == 2 && b == 8'h88) begin m_step = 0; m_unl = 1; end
            else begin m_step = 0; m_unl = 0; end
        end
    endtask

    task automatic key(input string tag);
        step(LOCK, 32'h59, 1, 0, tag);
        step(LOCK, 32'h16, 1, 0, tag);
        step(LOCK, 32'h88, 1, 0, tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        mismatched++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        // R1: reset state
        bus_addr = LOCK;
        #15;
        chk("R1", "rd_data in reset", rd_data, 32'h0);
        chk("R1", "unlock_o in reset", {31'b0, unlock_o}, 32'h0);
        @(negedge clk); rst_n = 1'b1;
        step(LOCK, 0, 0, 0, "R1");

        // R3 / R4 while locked
        step(PADR, 32'hFFFF, 1, 1, "R3");
        step(UADR, 32'h1234, 1, 0, "R4");
        step(PADR, 32'h1, 0, 1, "R4");
        step(LOCK, 32'h01, 1, 0, "R9");
        step(LOCK, 0, 0, 0, "R9");

        // R2 with upper bits set, R5 next-cycle permit
        step(LOCK, 32'hABCD_0059, 1, 0, "R2");
        step(LOCK, 32'h7700_0016, 1, 0, "R2");
        step(LOCK, 32'h0000_1188, 1, 0, "R5");
        step(PADR, 32'h5, 1, 1, "R5");
        step(LOCK, 0, 0, 0, "R9");
        step(UADR, 0, 0, 0, "R9");
        step(LOCK, 32'h59, 1, 0, "R10");

        // R7: 0x59 keeps open, partial key keeps open, stray byte closes
        step(PADR, 32'h6, 1, 1, "R7");
        step(LOCK, 32'h16, 1, 0, "R7");
        step(PADR, 32'h6, 1, 1, "R7");
        step(LOCK, 32'h01, 1, 0, "R7");
        step(PADR, 32'h6, 1, 1, "R7");
        key("R7");
        step(LOCK, 32'h00, 1, 0, "R7");
        step(PADR, 32'h6, 1, 1, "R7");

        // R6: restarts
        step(LOCK, 32'h59, 1, 0, "R6");
        step(LOCK, 32'h00, 1, 0, "R6");
        step(LOCK, 32'h88, 1, 0, "R6");
        step(LOCK, 32'h16, 1, 0, "R6");
        step(LOCK, 32'h59, 1, 0, "R6");
        step(LOCK, 32'h16, 1, 0, "R6");
        step(LOCK, 32'h16, 1, 0, "R6");
        step(LOCK, 32'h88, 1, 0, "R6");
        step(PADR, 32'h7, 1, 1, "R6");
        step(LOCK, 32'h59, 1, 0, "R6");
        step(LOCK, 32'h59, 1, 0, "R6");
        step(LOCK, 32'h16, 1, 0, "R6");
        step(LOCK, 32'h59, 1, 0, "R6");
        step(LOCK, 32'h16, 1, 0, "R6");
        step(LOCK, 32'h88, 1, 0, "R6");
        step(PADR, 32'h7, 1, 1, "R6");
        step(LOCK, 32'h02, 1, 0, "R6");

        // R8: interleaved traffic between key bytes
        step(LOCK, 32'h59, 1, 0, "R8");
        step(PADR, 32'h16, 1, 1, "R8");
        step(UADR, 32'h88, 1, 0, "R8");
        step(LOCK, 32'h16, 0, 0, "R8");
        step(LOCK, 32'h16, 1, 0, "R8");
        step(PADR, 32'h88, 1, 1, "R8");
        step(UADR, 32'h0, 0, 0, "R8");
        step(LOCK, 32'h88, 1, 0, "R8");
        step(PADR, 32'h9, 1, 1, "R8");
        step(LOCK, 0, 0, 0, "R8");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule